// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Bank

This block is the software-visible register file of a small multi-channel DMA controller. A single-word request port reads and writes a global region and one fixed-size window per channel. The global region holds a control word, two interrupt mask words and two interrupt source words. Each channel window holds a control/status word, a size word, source and destination addresses, two address masks, a link pointer and a software pointer. The transfer engine sits outside this block. It receives a start or cancel pulse for each channel and the channel's configuration bits. It reports chunk-complete, transfer-complete and error events back to the block.

Two state machines shape the behaviour. The response machine has two states. It moves from `RSP_IDLE` to `RSP_SEND` on every accepted read and returns to `RSP_IDLE` on any cycle without a read. Each channel has an enable machine. It goes from `CH_IDLE` to `CH_ARMED` on a control write with the enable bit set, which emits a start pulse. It goes from `CH_ARMED` to `CH_IDLE` on a control write with the enable bit clear, which emits a cancel pulse. It also goes from `CH_ARMED` to `CH_IDLE` on a complete or error event from the engine, unless a control write arrives in the same cycle.

Interrupts are gated twice. An event raises a channel flag only when both of these bits are set: the matching enable bit in the channel word, and the channel's bit in mask word A. The single interrupt line then stays high until software clears the source word or reads the channel word.

Top module: `dma_regbank`

## Requirements
- R1: After reset every register reads zero, except the two address-mask words of each channel (window offsets 3 and 5), which read 0xFFFFFFFC. In the same state `irq`, `start_o`, `cancel_o` and `ctrl_o` are low.
- R2: Global word offsets decode as follows: 0 = control, 1 = mask A, 2 = mask B, 3 = source A, 4 = source B. Addresses from CH_BASE upward decode as follows: channel = (addr−CH_BASE)/CH_WIN, register = (addr−CH_BASE) mod CH_WIN. The register order is 0 = control/status, 1 = size, 2 = source address, 3 = source mask, 4 = destination address, 5 = destination mask, 6 = link pointer, 7 = software pointer. Read data is returned with `bus_rvalid` high in the cycle after the request.
- R3: Undefined addresses read zero and ignore writes. These are global offsets 5 to 7, window offsets of 8 and above, and addresses at or beyond CH_BASE+NUM_CH·CH_WIN.
- R4: A write to the global control word, including its pause bit, has no effect, and the word always reads zero.
- R5: Channel word layout: bit 0 = enable, bits 1..4 = engine options, bit 5 = chunk interrupt enable, bit 6 = complete interrupt enable, bit 7 = error interrupt enable, bit 8 = complete status, bit 9 = error status, bits 10/11/12 = chunk/complete/error interrupt flags. A write changes only bits 7:0.
- R6: A read of a channel word returns its value before the read. It then clears bits 9 to 12, and leaves bit 8 unchanged. An event in the same cycle sets its bits after the clear.
- R7: A channel-word write with bit 0 set, made while the channel is idle, gives one `start_o` pulse in the following cycle. The same write while the channel is armed gives no pulse.
- R8: A channel-word write with bit 0 clear gives one `cancel_o` pulse in the following cycle, whatever the prior state.
- R9: A complete event sets bit 8 and clears bit 9. An error event sets bit 9. Either event clears bit 0, unless a channel-word write in the same cycle sets bit 0 itself.
- R10: An event sets its interrupt flag only if both its enable bit and the channel's bit in mask A are set. A firing channel writes its one-hot mask into source A. If several channels fire in one cycle, the highest channel wins, and a firing channel overrides a software write to source A in the same cycle.
- R11: `irq` is high exactly when some channel has its source A bit set and at least one of its interrupt flags (bits 10..12) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data returned this cycle |
| ev_chunk | input | NUM_CH | Chunk-complete event per channel |
| ev_done | input | NUM_CH | Transfer-complete event per channel |
| ev_err | input | NUM_CH | Error event per channel |
| start_o | output | NUM_CH | One-cycle start pulse per channel |
| cancel_o | output | NUM_CH | One-cycle cancel pulse per channel |
| ctrl_o | output | NUM_CH*8 | Bits 7:0 of each channel word, channel c at [8c+7:8c] |
| irq | output | 1 | Merged interrupt request |

## Verification
All state is sampled at a rising edge. Register contents, status flags, mask and source words, and `irq` therefore reflect a write or event from the first falling edge after that rising edge. `bus_rvalid` with `bus_rdata`, `start_o` and `cancel_o` are registered results of the same edge, so they are also due one cycle after the stimulus. The bench applies each stimulus at a falling edge and advances its behavioural model by exactly one clock. At the next falling edge it compares every output against the model, which keeps each comparison at the single cycle where the result is due.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
    localparam int unsigned DW    = 32;
    localparam int unsigned CFG_W = 8;

    // channel word bit positions
    localparam int unsigned B_EN       = 0;
    localparam int unsigned B_IE_CHUNK = 5;
    localparam int unsigned B_IE_DONE  = 6;
    localparam int unsigned B_IE_ERR   = 7;

    // global offsets
    localparam logic [2:0] G_CTRL = 3'd0;
    localparam logic [2:0] G_MSKA = 3'd1;
    localparam logic [2:0] G_MSKB = 3'd2;
    localparam logic [2:0] G_SRCA = 3'd3;
    localparam logic [2:0] G_SRCB = 3'd4;

    // channel window offsets
    localparam logic [2:0] R_CSR  = 3'd0;
    localparam logic [2:0] R_SMSK = 3'd3;
    localparam logic [2:0] R_DMSK = 3'd5;

    localparam logic [DW-1:0] MASK_RST = 32'hFFFF_FFFC;

    typedef enum logic { CH_IDLE, CH_ARMED } ch_state_e;
    typedef enum logic { RSP_IDLE, RSP_SEND } rsp_state_e;
endpackage

// File: rtl/dmarb_decode.sv
module dmarb_decode
    import dmarb_pkg::*;
#(
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned NUM_CH  = 4,
    parameter int unsigned CH_BASE = 8,
    parameter int unsigned CH_WIN  = 8,
    parameter int unsigned CH_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              glob_hit,
    output logic [2:0]        glob_sel,
    output logic              chan_hit,
    output logic [CH_W-1:0]   chan_idx,
    output logic [2:0]        reg_idx
);
    always_comb begin
        int unsigned a;
        int unsigned rel;
        int unsigned chn;
        int unsigned sub;
        a        = 32'(addr);
        rel      = (a >= CH_BASE) ? (a - CH_BASE) : 0;
        chn      = rel / CH_WIN;
        sub      = rel % CH_WIN;
        glob_hit = (a < CH_BASE) && (a <= 32'(G_SRCB));
        glob_sel = a[2:0];
        chan_hit = (a >= CH_BASE) && (chn < NUM_CH) && (sub < 8);
        chan_idx = CH_W'(chn);
        reg_idx  = sub[2:0];
    end
endmodule

// File: rtl/dmarb_chan.sv
module dmarb_chan
    import dmarb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [2:0]       reg_idx,
    input  logic [DW-1:0]    wdata,
    input  logic             msk_bit,
    input  logic             ev_chunk,
    input  logic             ev_done,
    input  logic             ev_err,
    output logic [DW-1:0]    rd_word,
    output logic [CFG_W-1:0] ctrl,
    output logic             pend,
    output logic             fire,
    output logic             start,
    output logic             cancel
);
    ch_state_e          state_q, state_d;
    logic [CFG_W-1:1]   cfg_q;
    logic               done_q, err_q, fc_q, fd_q, fe_q;
    logic               done_d, err_d, fc_d, fd_d, fe_d;
    logic [DW-1:0]      regs_q [8];
    logic               wr_csr, rd_csr;
    logic               fire_c, fire_d, fire_e;
    logic [DW-1:0]      csr_word;

    assign wr_csr = wr_en && (reg_idx == R_CSR);
    assign rd_csr = rd_en && (reg_idx == R_CSR);

    assign fire_c = ev_chunk && cfg_q[B_IE_CHUNK] && msk_bit;
    assign fire_d = ev_done  && cfg_q[B_IE_DONE]  && msk_bit;
    assign fire_e = ev_err   && cfg_q[B_IE_ERR]   && msk_bit;
    assign fire   = fire_c || fire_d || fire_e;

    assign csr_word = {19'b0, fe_q, fd_q, fc_q, err_q, done_q, cfg_q,
                       (state_q == CH_ARMED)};
    assign ctrl     = csr_word[CFG_W-1:0];
    assign pend     = fc_q || fd_q || fe_q;
    assign rd_word  = (reg_idx == R_CSR) ? csr_word : regs_q[reg_idx];

    // enable state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (wr_csr && wdata[B_EN]) state_d = CH_ARMED;
            end
            CH_ARMED: begin
                if (wr_csr) begin
                    if (!wdata[B_EN]) state_d = CH_IDLE;
                end else if (ev_done || ev_err) begin
                    state_d = CH_IDLE;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // pulse outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start  <= 1'b0;
            cancel <= 1'b0;
        end else begin
            start  <= wr_csr && wdata[B_EN] && (state_q == CH_IDLE);
            cancel <= wr_csr && !wdata[B_EN];
        end
    end

    // status flags: read-clear first, events set after
    always_comb begin
        done_d = done_q;
        err_d  = err_q;
        fc_d   = fc_q;
        fd_d   = fd_q;
        fe_d   = fe_q;
        if (rd_csr) begin
            err_d = 1'b0;
            fc_d  = 1'b0;
            fd_d  = 1'b0;
            fe_d  = 1'b0;
        end
        if (ev_done) begin
            done_d = 1'b1;
            err_d  = 1'b0;
        end
        if (ev_err) err_d = 1'b1;
        if (fire_c) fc_d = 1'b1;
        if (fire_d) fd_d = 1'b1;
        if (fire_e) fe_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            fc_q   <= 1'b0;
            fd_q   <= 1'b0;
            fe_q   <= 1'b0;
        end else begin
            if (wr_csr) cfg_q <= wdata[CFG_W-1:1];
            done_q <= done_d;
            err_q  <= err_d;
            fc_q   <= fc_d;
            fd_q   <= fd_d;
            fe_q   <= fe_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 8; k++) begin
                regs_q[k] <= (3'(k) == R_SMSK || 3'(k) == R_DMSK) ? MASK_RST : '0;
            end
        end else if (wr_en && reg_idx != R_CSR) begin
            regs_q[reg_idx] <= wdata;
        end
    end

    // R6
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_csr && !ev_err && !fire) |=> (!err_q && !fc_q && !fd_q && !fe_q));
    // R7
    start_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state_q == CH_ARMED));
    // R8
    cancel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |-> (state_q == CH_IDLE));
    // R5
    csr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_csr |=> (ctrl == $past(wdata[CFG_W-1:0])));
endmodule

// File: rtl/dmarb_glob.sv
module dmarb_glob
    import dmarb_pkg::*;
#(
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        sel,
    input  logic [DW-1:0]     wdata,
    input  logic [NUM_CH-1:0] fire,
    input  logic [NUM_CH-1:0] pend,
    output logic [NUM_CH-1:0] msk_a_o,
    output logic [DW-1:0]     rd_word,
    output logic              irq
);
    logic [DW-1:0] msk_a_q, msk_b_q, src_a_q, src_b_q;
    logic [DW-1:0] hw_src;
    logic          hw_any;

    // highest firing channel wins
    always_comb begin
        hw_src = '0;
        hw_any = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (fire[c]) begin
                hw_src    = '0;
                hw_src[c] = 1'b1;
                hw_any    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msk_a_q <= '0;
            msk_b_q <= '0;
            src_a_q <= '0;
            src_b_q <= '0;
        end else begin
            if (wr_en && sel == G_MSKA) msk_a_q <= wdata;
            if (wr_en && sel == G_MSKB) msk_b_q <= wdata;
            if (wr_en && sel == G_SRCB) src_b_q <= wdata;
            if (hw_any)                      src_a_q <= hw_src;
            else if (wr_en && sel == G_SRCA) src_a_q <= wdata;
        end
    end

    always_comb begin
        unique case (sel)
            G_MSKA:  rd_word = msk_a_q;
            G_MSKB:  rd_word = msk_b_q;
            G_SRCA:  rd_word = src_a_q;
            G_SRCB:  rd_word = src_b_q;
            default: rd_word = '0;
        endcase
    end

    assign msk_a_o = msk_a_q[NUM_CH-1:0];
    assign irq     = |(src_a_q[NUM_CH-1:0] & pend);

    // R11
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (src_a_q != '0));
    // R10
    src_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|fire) |=> ($countones(src_a_q) == 1));
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
    import dmarb_pkg::*;
#(
    parameter int unsigned NUM_CH  = 4,
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned CH_BASE = 8,
    parameter int unsigned CH_WIN  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_en,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic                    bus_rvalid,
    input  logic [NUM_CH-1:0]       ev_chunk,
    input  logic [NUM_CH-1:0]       ev_done,
    input  logic [NUM_CH-1:0]       ev_err,
    output logic [NUM_CH-1:0]       start_o,
    output logic [NUM_CH-1:0]       cancel_o,
    output logic [NUM_CH*CFG_W-1:0] ctrl_o,
    output logic                    irq
);
    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic              rd_req, wr_req;
    logic              glob_hit, chan_hit;
    logic [2:0]        glob_sel, reg_idx;
    logic [CH_W-1:0]   chan_idx;
    logic [DW-1:0]     glob_rd, rd_mux;
    logic [DW-1:0]     ch_rd [NUM_CH];
    logic [NUM_CH-1:0] msk_a, fire, pend;
    rsp_state_e        rsp_q, rsp_d;

    assign rd_req = bus_en && !bus_we;
    assign wr_req = bus_en && bus_we;

    dmarb_decode #(
        .ADDR_W (ADDR_W), .NUM_CH (NUM_CH), .CH_BASE (CH_BASE),
        .CH_WIN (CH_WIN), .CH_W (CH_W)
    ) u_dec (
        .addr     (bus_addr),
        .glob_hit (glob_hit),
        .glob_sel (glob_sel),
        .chan_hit (chan_hit),
        .chan_idx (chan_idx),
        .reg_idx  (reg_idx)
    );

    dmarb_glob #(.NUM_CH (NUM_CH)) u_glob (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_req && glob_hit),
        .sel     (glob_sel),
        .wdata   (bus_wdata),
        .fire    (fire),
        .pend    (pend),
        .msk_a_o (msk_a),
        .rd_word (glob_rd),
        .irq     (irq)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel_c;
        assign sel_c = chan_hit && (chan_idx == CH_W'(c));
        dmarb_chan u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_req && sel_c),
            .rd_en    (rd_req && sel_c),
            .reg_idx  (reg_idx),
            .wdata    (bus_wdata),
            .msk_bit  (msk_a[c]),
            .ev_chunk (ev_chunk[c]),
            .ev_done  (ev_done[c]),
            .ev_err   (ev_err[c]),
            .rd_word  (ch_rd[c]),
            .ctrl     (ctrl_o[c*CFG_W +: CFG_W]),
            .pend     (pend[c]),
            .fire     (fire[c]),
            .start    (start_o[c]),
            .cancel   (cancel_o[c])
        );
    end

    always_comb begin
        rd_mux = '0;
        if (glob_hit)      rd_mux = glob_rd;
        else if (chan_hit) rd_mux = ch_rd[chan_idx];
    end

    // response state machine
    always_comb begin
        rsp_d = RSP_IDLE;
        unique case (rsp_q)
            RSP_IDLE: if (rd_req) rsp_d = RSP_SEND;
            RSP_SEND: if (rd_req) rsp_d = RSP_SEND;
            default:  rsp_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= RSP_IDLE;
        else        rsp_q <= rsp_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_req) bus_rdata <= rd_mux;
    end

    assign bus_rvalid = (rsp_q == RSP_SEND);

    // R2
    rvalid_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);
    // R2
    rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid);
    // R3
    undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !glob_hit && !chan_hit) |=> (bus_rdata == '0));
endmodule

// File: tb/dma_regbank_tb.sv
module dma_regbank_tb;
    localparam int NCH = 4;
    localparam int CHB = 8;
    localparam int CHW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_en = 1'b0, bus_we = 1'b0;
    logic [5:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [NCH-1:0]    ev_chunk = '0, ev_done = '0, ev_err = '0;
    logic [NCH-1:0]    start_o, cancel_o;
    logic [NCH*8-1:0]  ctrl_o;
    logic              irq;

    int total = 0;
    int bad   = 0;

    // behavioural model
    logic [15:0]    m_csr [NCH];
    logic [31:0]    m_reg [NCH][8];
    logic [31:0]    m_msk_a, m_msk_b, m_src_a, m_src_b;
    logic [NCH-1:0] m_start, m_cancel;
    logic           m_rvalid;
    logic [31:0]    m_rdata;

    always #10 clk = ~clk;

    dma_regbank u_dut (
        .clk (clk), .rst_n (rst_n), .bus_en (bus_en), .bus_we (bus_we),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .bus_rvalid (bus_rvalid), .ev_chunk (ev_chunk), .ev_done (ev_done),
        .ev_err (ev_err), .start_o (start_o), .cancel_o (cancel_o),
        .ctrl_o (ctrl_o), .irq (irq)
    );

    function automatic int ca(int c, int k);
        return CHB + CHW * c + k;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_csr[c] = '0;
            for (int k = 0; k < 8; k++)
                m_reg[c][k] = (k == 3 || k == 5) ? 32'hFFFF_FFFC : 32'h0;
        end
        m_msk_a = 0; m_msk_b = 0; m_src_a = 0; m_src_b = 0;
        m_start = '0; m_cancel = '0; m_rvalid = 0; m_rdata = 0;
    endtask

    function automatic logic [31:0] m_read(int a);
        int c;
        int k;
        if (a < CHB) begin
            case (a)
                1: return m_msk_a;
                2: return m_msk_b;
                3: return m_src_a;
                4: return m_src_b;
                default: return 32'h0;
            endcase
        end
        if (a < CHB + CHW * NCH) begin
            c = (a - CHB) / CHW;
            k = (a - CHB) % CHW;
            if (k == 0) return {16'h0, m_csr[c]};
            return m_reg[c][k];
        end
        return 32'h0;
    endfunction

    function automatic logic m_irq();
        logic r = 1'b0;
        for (int c = 0; c < NCH; c++)
            if (m_src_a[c] && (|m_csr[c][12:10])) r = 1'b1;
        return r;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check("R2", "rvalid", 32'(bus_rvalid), 32'(m_rvalid));
        if (m_rvalid) check(tag, "rdata", bus_rdata, m_rdata);
        check("R7", "start", 32'(start_o), 32'(m_start));
        check("R8", "cancel", 32'(cancel_o), 32'(m_cancel));
        check("R11", "irq", 32'(irq), 32'(m_irq()));
        for (int c = 0; c < NCH; c++)
            check("R5", "ctrl", 32'(ctrl_o[c*8 +: 8]), 32'(m_csr[c][7:0]));
    endtask

    // one clock: drive at falling edge, model one edge, compare at next falling edge
    task automatic step(string tag, bit en, bit we, int addr, logic [31:0] wd,
                        logic [NCH-1:0] ec, logic [NCH-1:0] ed, logic [NCH-1:0] ee);
        logic [15:0]    p_csr [NCH];
        logic [31:0]    p_msk;
        logic [NCH-1:0] cw;
        int             c;
        int             k;
        int             fired;
        bus_en = en; bus_we = we; bus_addr = 6'(addr); bus_wdata = wd;
        ev_chunk = ec; ev_done = ed; ev_err = ee;
        for (int i = 0; i < NCH; i++) p_csr[i] = m_csr[i];
        p_msk = m_msk_a;
        cw = '0; fired = -1;
        m_start = '0; m_cancel = '0;
        m_rvalid = en && !we;
        if (m_rvalid) m_rdata = m_read(addr);
        c = (addr - CHB) / CHW;
        k = (addr - CHB) % CHW;
        if (en && !we && addr >= CHB && addr < CHB + CHW * NCH && k == 0)
            m_csr[c] = m_csr[c] & ~16'h1E00;
        if (en && we) begin
            if (addr < CHB) begin
                case (addr)
                    1: m_msk_a = wd;
                    2: m_msk_b = wd;
                    3: m_src_a = wd;
                    4: m_src_b = wd;
                    default: ;
                endcase
            end else if (addr < CHB + CHW * NCH) begin
                if (k == 0) begin
                    m_start[c]  = !m_csr[c][0] && wd[0];
                    m_cancel[c] = !wd[0];
                    m_csr[c][7:0] = wd[7:0];
                    cw[c] = 1'b1;
                end else begin
                    m_reg[c][k] = wd;
                end
            end
        end
        for (int i = 0; i < NCH; i++) begin
            if (ed[i]) begin
                m_csr[i][8] = 1'b1; m_csr[i][9] = 1'b0;
                if (!cw[i]) m_csr[i][0] = 1'b0;
                if (p_csr[i][6] && p_msk[i]) begin m_csr[i][11] = 1'b1; fired = i; end
            end
            if (ee[i]) begin
                m_csr[i][9] = 1'b1;
                if (!cw[i]) m_csr[i][0] = 1'b0;
                if (p_csr[i][7] && p_msk[i]) begin m_csr[i][12] = 1'b1; fired = i; end
            end
            if (ec[i] && p_csr[i][5] && p_msk[i]) begin m_csr[i][10] = 1'b1; fired = i; end
        end
        if (fired >= 0) m_src_a = 32'h1 << fired;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic wr(string tag, int a, logic [31:0] d);
        step(tag, 1, 1, a, d, '0, '0, '0);
    endtask
    task automatic rd(string tag, int a);
        step(tag, 1, 0, a, 0, '0, '0, '0);
    endtask
    task automatic ev(string tag, logic [NCH-1:0] ec, logic [NCH-1:0] ed, logic [NCH-1:0] ee);
        step(tag, 0, 0, 0, 0, ec, ed, ee);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total + 1, bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state at the ports
        compare("R1");
        check("R1", "irq", 32'(irq), 32'h0);
        for (int a = 0; a < 5; a++) rd("R1", a);
        for (int k = 0; k < 8; k++) rd("R1", ca(0, k));
        rd("R1", ca(3, 3));
        rd("R1", ca(3, 5));
        check("R1", "am1 value", bus_rdata, 32'hFFFF_FFFC);

        // R2 register decode and readback
        for (int k = 1; k < 8; k++) wr("R2", ca(1, k), 32'h1100_0000 + 32'(k) * 32'h0101);
        for (int k = 1; k < 8; k++) rd("R2", ca(1, k));
        rd("R2", ca(2, 2));
        wr("R2", 2, 32'hA5A5_0001);
        wr("R2", 4, 32'h0000_00C3);
        rd("R2", 2);
        rd("R2", 4);

        // R4 global control ignores writes
        wr("R4", 0, 32'hFFFF_FFFF);
        rd("R4", 0);

        // R3 undefined addresses
        wr("R3", 5, 32'hDEAD_BEEF);
        rd("R3", 5);
        rd("R3", 7);
        wr("R3", 45, 32'h1234_5678);
        rd("R3", 45);
        rd("R3", 63);

        // R5 / R7 / R8 channel word write mask and enable edges
        wr("R5", ca(0, 0), 32'hFFFF_FFFF);
        rd("R5", ca(0, 0));
        wr("R7", ca(0, 0), 32'h0000_0003);
        wr("R8", ca(0, 0), 32'h0000_0000);
        wr("R8", ca(0, 0), 32'h0000_0000);
        wr("R7", ca(2, 0), 32'h0000_0001);

        // R9 / R10 / R11 complete event with interrupt
        wr("R10", 1, 32'h0000_000F);
        wr("R10", ca(0, 0), 32'h0000_00E1);
        ev("R9", 4'b0000, 4'b0001, 4'b0000);
        rd("R10", 3);
        rd("R6", ca(0, 0));
        rd("R6", ca(0, 0));
        ev("R11", 4'b0000, 4'b0000, 4'b0000);

        // R10 mask bit clear blocks the flag
        wr("R10", ca(2, 0), 32'h0000_0021);
        wr("R10", 1, 32'h0000_0003);
        ev("R10", 4'b0100, 4'b0000, 4'b0000);
        rd("R10", ca(2, 0));
        rd("R10", 3);

        // R10 two channels fire with a software write to source A
        wr("R10", ca(1, 0), 32'h0000_0081);
        wr("R10", ca(0, 0), 32'h0000_00C1);
        step("R10", 1, 1, 3, 32'h0000_0008, 4'b0000, 4'b0001, 4'b0010);
        rd("R10", 3);
        rd("R9", ca(1, 0));

        // R11 clearing source A drops irq, flags stay
        wr("R11", 3, 32'h0);
        rd("R11", ca(0, 0));

        // R9 channel write races a complete event
        wr("R9", ca(3, 0), 32'h0000_00C1);
        step("R9", 1, 1, ca(3, 0), 32'h0000_0041, 4'b0000, 4'b1000, 4'b0000);
        rd("R9", ca(3, 0));
        ev("R9", 4'b0000, 4'b1000, 4'b1000);
        rd("R9", ca(3, 0));

        // R6 read-clear races an error event
        wr("R6", 1, 32'h0000_000F);
        step("R6", 1, 0, ca(1, 0), 0, 4'b0000, 4'b0000, 4'b0010);
        rd("R6", ca(1, 0));
        rd("R6", ca(1, 0));
        ev("R6", 4'b0000, 4'b0000, 4'b0000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule